// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands of the instruction now in the execute stage of a five-stage pipeline, where that operand's value comes from. An operand can be the value read from the register file during decode. It can also be the result still held one stage ahead, in the memory stage, or the value about to be written back two stages ahead. The block compares the two source register numbers of the executing instruction against the destination numbers of those two older instructions. It produces a 2-bit select per operand and the operand value that the select picks.

The unit is purely combinational and sits between the decode/execute pipeline register and the ALU inputs. The instruction three positions ahead needs no bypass: the register file writes in the first half of a cycle and reads in the second half, so decode already saw that value. Stalling after loads and the register file itself lie outside this block.

Top module: `fwd_unit`

## Requirements
- R1: When the memory-stage instruction writes a register (write flag 1, destination not 0) whose number equals source A, select A is 2'b10 and operand A equals the memory-stage result.
- R2: When the memory-stage instruction writes a register (write flag 1, destination not 0) whose number equals source B, select B is 2'b10 and operand B equals the memory-stage result.
- R3: When only the writeback-stage instruction writes a non-zero register equal to source A, select A is 2'b01 and operand A equals the writeback value.
- R4: When only the writeback-stage instruction writes a non-zero register equal to source B, select B is 2'b01 and operand B equals the writeback value.
- R5: When both the memory stage and the writeback stage match the same source, the memory stage wins: the select is 2'b10.
- R6: A stage whose write flag is 0 never causes a bypass, even when its destination equals a source.
- R7: Destination register 0 never causes a bypass, whatever the write flag.
- R8: With no qualifying match, the select is 2'b00 and the operand equals the register-file value.
- R9: Operands A and B are decided independently; both may bypass from the same producer at once.
- R10: A select never takes the value 2'b11.
- R11: Each operand output equals the input named by its select (00 register file, 10 memory-stage result, 01 writeback value).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_idx | input | REG_AW | Source register number of operand A in execute |
| ex_src_b_idx | input | REG_AW | Source register number of operand B in execute |
| mem_dst_idx | input | REG_AW | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_result | input | XLEN | ALU result held in the memory stage |
| wb_dst_idx | input | REG_AW | Destination register of the writeback-stage instruction |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| wb_value | input | XLEN | Value being written back |
| rf_a_val | input | XLEN | Register-file value read for operand A |
| rf_b_val | input | XLEN | Register-file value read for operand B |
| fwd_sel_a | output | 2 | Source select for operand A |
| fwd_sel_b | output | 2 | Source select for operand B |
| opnd_a | output | XLEN | Operand A delivered to the ALU |
| opnd_b | output | XLEN | Operand B delivered to the ALU |

## Verification
The bench sweeps every combination of source numbers, destination numbers and write flags over a set of register numbers that includes register 0 and the highest register. It computes each expected select and operand arithmetically. The sweep targets the double match, where a design with reversed priority would hand the ALU a stale value from the older instruction. It also targets a destination of 0 with the write flag set, where a design that skips that test would bypass a value from a register that is hard-wired to zero. A third target is the disabled write flag: a bypass there would inject the result of a store or branch. The last is an instruction that reads the same producer register on both operands, where a design that shares one comparison would feed only one of the two operands.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    // Operand source codes seen at the block's outputs.
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_t;

    localparam int unsigned NUM_OPND = 2;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int unsigned REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_idx,
    input  logic [REG_AW-1:0] dst_idx,
    input  logic              wen,
    output logic              hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wen && (dst_idx != ZERO_REG) && (dst_idx == src_idx);
    end
endmodule

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
(
    input  logic     hit_near,
    input  logic     hit_far,
    output fwd_sel_t sel
);
    typedef struct packed {
        fwd_sel_t sel;
    } sel_state_t;

    sel_state_t state_d;

    always_comb begin
        state_d.sel = SEL_RF;
        if (hit_near) begin
            state_d.sel = SEL_MEM;
        end else if (hit_far) begin
            state_d.sel = SEL_WB;
        end
    end

    assign sel = state_d.sel;
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
    import fwd_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  fwd_sel_t          sel,
    input  logic [XLEN-1:0]   rf_val,
    input  logic [XLEN-1:0]   near_val,
    input  logic [XLEN-1:0]   far_val,
    output logic [XLEN-1:0]   opnd
);
    always_comb begin
        unique case (sel)
            SEL_MEM: opnd = near_val;
            SEL_WB:  opnd = far_val;
            default: opnd = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned XLEN   = 32
) (
    input  logic [REG_AW-1:0] ex_src_a_idx,
    input  logic [REG_AW-1:0] ex_src_b_idx,
    input  logic [REG_AW-1:0] mem_dst_idx,
    input  logic              mem_wen,
    input  logic [XLEN-1:0]   mem_result,
    input  logic [REG_AW-1:0] wb_dst_idx,
    input  logic              wb_wen,
    input  logic [XLEN-1:0]   wb_value,
    input  logic [XLEN-1:0]   rf_a_val,
    input  logic [XLEN-1:0]   rf_b_val,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic [XLEN-1:0]   opnd_a,
    output logic [XLEN-1:0]   opnd_b
);
    logic [REG_AW-1:0] src_idx [NUM_OPND];
    logic [XLEN-1:0]   rf_val  [NUM_OPND];
    fwd_sel_t          sel     [NUM_OPND];
    logic [XLEN-1:0]   opnd    [NUM_OPND];

    assign src_idx[0] = ex_src_a_idx;
    assign src_idx[1] = ex_src_b_idx;
    assign rf_val[0]  = rf_a_val;
    assign rf_val[1]  = rf_b_val;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        logic hit_mem;
        logic hit_wb;

        fwd_match #(.REG_AW(REG_AW)) mem_cmp_i (
            .src_idx (src_idx[g]),
            .dst_idx (mem_dst_idx),
            .wen     (mem_wen),
            .hit     (hit_mem)
        );

        fwd_match #(.REG_AW(REG_AW)) wb_cmp_i (
            .src_idx (src_idx[g]),
            .dst_idx (wb_dst_idx),
            .wen     (wb_wen),
            .hit     (hit_wb)
        );

        fwd_select sel_i (
            .hit_near (hit_mem),
            .hit_far  (hit_wb),
            .sel      (sel[g])
        );

        fwd_opmux #(.XLEN(XLEN)) mux_i (
            .sel      (sel[g]),
            .rf_val   (rf_val[g]),
            .near_val (mem_result),
            .far_val  (wb_value),
            .opnd     (opnd[g])
        );
    end

    assign fwd_sel_a = sel[0];
    assign fwd_sel_b = sel[1];
    assign opnd_a    = opnd[0];
    assign opnd_b    = opnd[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned XLEN   = 32
) (
    input logic [REG_AW-1:0] ex_src_a_idx,
    input logic [REG_AW-1:0] ex_src_b_idx,
    input logic [REG_AW-1:0] mem_dst_idx,
    input logic              mem_wen,
    input logic [XLEN-1:0]   mem_result,
    input logic [REG_AW-1:0] wb_dst_idx,
    input logic              wb_wen,
    input logic [XLEN-1:0]   wb_value,
    input logic [XLEN-1:0]   rf_a_val,
    input logic [XLEN-1:0]   rf_b_val,
    input logic [1:0]        fwd_sel_a,
    input logic [1:0]        fwd_sel_b,
    input logic [XLEN-1:0]   opnd_a,
    input logic [XLEN-1:0]   opnd_b
);
    always_comb begin
        // R10
        sel_code_legal_chk: assert (fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11);
        // R7
        if (ex_src_a_idx == '0) begin
            src_zero_a_chk: assert (fwd_sel_a == 2'b00);
        end
        // R6
        if (!mem_wen && !wb_wen) begin
            no_writer_chk: assert (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00);
        end
        // R5
        if (mem_wen && mem_dst_idx != '0 && mem_dst_idx == ex_src_b_idx) begin
            near_wins_b_chk: assert (fwd_sel_b == 2'b10);
        end
        // R11
        if (fwd_sel_a == 2'b10) begin
            route_a_mem_chk: assert (opnd_a == mem_result);
        end else if (fwd_sel_a == 2'b01) begin
            route_a_wb_chk: assert (opnd_a == wb_value);
        end else begin
            route_a_rf_chk: assert (opnd_a == rf_a_val);
        end
        // R11
        if (fwd_sel_b == 2'b10) begin
            route_b_mem_chk: assert (opnd_b == mem_result);
        end else if (fwd_sel_b == 2'b01) begin
            route_b_wb_chk: assert (opnd_b == wb_value);
        end else begin
            route_b_rf_chk: assert (opnd_b == rf_b_val);
        end
    end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW), .XLEN(XLEN)) chk_i (
    .ex_src_a_idx (ex_src_a_idx),
    .ex_src_b_idx (ex_src_b_idx),
    .mem_dst_idx  (mem_dst_idx),
    .mem_wen      (mem_wen),
    .mem_result   (mem_result),
    .wb_dst_idx   (wb_dst_idx),
    .wb_wen       (wb_wen),
    .wb_value     (wb_value),
    .rf_a_val     (rf_a_val),
    .rf_b_val     (rf_b_val),
    .fwd_sel_a    (fwd_sel_a),
    .fwd_sel_b    (fwd_sel_b),
    .opnd_a       (opnd_a),
    .opnd_b       (opnd_b)
);

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned AW = 5;
    localparam int unsigned XW = 32;

    logic          clk = 1'b0;
    logic [AW-1:0] src_a, src_b, mdst, wdst;
    logic          mwen, wwen;
    logic [XW-1:0] mres, wval, rfa, rfb;
    logic [1:0]    sel_a, sel_b;
    logic [XW-1:0] op_a, op_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwd_unit #(.REG_AW(AW), .XLEN(XW)) dut_i (
        .ex_src_a_idx (src_a),
        .ex_src_b_idx (src_b),
        .mem_dst_idx  (mdst),
        .mem_wen      (mwen),
        .mem_result   (mres),
        .wb_dst_idx   (wdst),
        .wb_wen       (wwen),
        .wb_value     (wval),
        .rf_a_val     (rfa),
        .rf_b_val     (rfb),
        .fwd_sel_a    (sel_a),
        .fwd_sel_b    (sel_b),
        .opnd_a       (op_a),
        .opnd_b       (op_b)
    );

    task automatic check(input string tag, input logic [XW-1:0] act, input logic [XW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
        logic near, far;
        near = mwen && (mdst != 0) && (mdst == s);
        far  = wwen && (wdst != 0) && (wdst == s);
        if (near) return 2'b10;
        if (far)  return 2'b01;
        return 2'b00;
    endfunction

    function automatic string tag_of(input logic [AW-1:0] s, input bit is_b);
        logic near, far;
        near = mwen && (mdst != 0) && (mdst == s);
        far  = wwen && (wdst != 0) && (wdst == s);
        if (near && far) return "R5";
        if (near) return is_b ? "R2" : "R1";
        if (far)  return is_b ? "R4" : "R3";
        if (s != 0 && ((mdst == s && !mwen) || (wdst == s && !wwen))) return "R6";
        if (s == 0 && (mdst == 0 || wdst == 0)) return "R7";
        return "R8";
    endfunction

    function automatic logic [XW-1:0] pick(input logic [1:0] sl, input logic [XW-1:0] rf);
        case (sl)
            2'b10:   return mres;
            2'b01:   return wval;
            default: return rf;
        endcase
    endfunction

    task automatic check_all();
        logic [1:0] ea, eb;
        ea = exp_sel(src_a);
        eb = exp_sel(src_b);
        check(tag_of(src_a, 1'b0), {30'd0, sel_a}, {30'd0, ea});
        check(tag_of(src_b, 1'b1), {30'd0, sel_b}, {30'd0, eb});
        check("R10", {31'd0, sel_a == 2'b11 || sel_b == 2'b11}, 32'd0);
        check("R11 opnd_a", op_a, pick(ea, rfa));
        check("R11 opnd_b", op_b, pick(eb, rfb));
    endtask

    initial begin
        logic [AW-1:0] regs [4];
        regs[0] = 5'd0; regs[1] = 5'd1; regs[2] = 5'd2; regs[3] = 5'd31;
        mres = 32'hA000_0001; wval = 32'hB000_0002;
        rfa  = 32'hC000_0003; rfb  = 32'hD000_0004;
        src_a = '0; src_b = '0; mdst = '0; wdst = '0; mwen = 1'b0; wwen = 1'b0;

        // Idle state: nothing writes, register-file values pass (R8)
        @(negedge clk);
        check("R8 idle sel_a", {30'd0, sel_a}, 32'd0);
        check("R8 idle opnd_b", op_b, rfb);

        // R9: same producer feeds both operands
        @(posedge clk);
        src_a = 5'd7; src_b = 5'd7; mdst = 5'd7; mwen = 1'b1;
        @(negedge clk);
        check("R9 sel_a", {30'd0, sel_a}, 32'd2);
        check("R9 sel_b", {30'd0, sel_b}, 32'd2);
        check("R9 opnd_a", op_a, mres);
        check("R9 opnd_b", op_b, mres);

        // R7: destination 0 with write flag set
        @(posedge clk);
        src_a = 5'd0; src_b = 5'd0; mdst = 5'd0; wdst = 5'd0; mwen = 1'b1; wwen = 1'b1;
        @(negedge clk);
        check("R7 opnd_a", op_a, rfa);
        check("R7 opnd_b", op_b, rfb);

        // Full sweep
        for (int ia = 0; ia < 4; ia++)
        for (int ib = 0; ib < 4; ib++)
        for (int im = 0; im < 4; im++)
        for (int iw = 0; iw < 4; iw++)
        for (int em = 0; em < 2; em++)
        for (int ew = 0; ew < 2; ew++) begin
            @(posedge clk);
            src_a = regs[ia]; src_b = regs[ib];
            mdst = regs[im]; wdst = regs[iw];
            mwen = em[0]; wwen = ew[0];
            mres = 32'hA000_0000 + 32'(ia * 64 + ib * 16 + im * 4 + iw);
            wval = 32'hB000_0000 + 32'(em * 2 + ew);
            @(negedge clk);
            check_all();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule